// File: doc/BRIEF.md
# Indirect PCI Configuration and I/O Access Port

This block sits in a 4 KiB register page and lets a CPU reach PCI configuration space and PCI I/O space without mapping either directly. Software first loads a 32-bit target address into an address register. It then reads or writes through one of two data windows: the configuration window or the I/O window. Each window access becomes a single downstream request to the PCI transaction engine. The block holds that request until the engine acknowledges it, then returns the completion and any read data to the CPU side.

The block also checks every access for legality. It checks the byte offset, and it checks the access size against the byte lane that the offset selects. An illegal access completes at once with an error flag and has no effect. Two small side registers share the page: a two-bit fast back-to-back enable register and a crash-vector address register whose upper pattern is fixed. Configuration data is passed in little-endian lane order. I/O data is passed big-endian, so the byte at the lowest address is the most significant byte of the CPU value.

Top module: `pcicfg_io_port`

## Requirements
- R1: The address register at offset 0x064 stores all 32 written bits and reads them back unchanged, including bits [1:0]. It accepts only 4-byte accesses; any other size is illegal.
- R2: A configuration window access (offsets 0x068 to 0x06B) issues a request with dn_io=0. Its dn_addr is the stored address with bits [1:0] cleared, ORed with the offset's low two bits. No enable bit of the stored address is checked, so a request is issued even when bit 31 is 0.
- R3: An I/O window access (offsets 0x06C to 0x06F) issues a request with dn_io=1. Its dn_addr is the stored address with bits [1:0] cleared, plus the offset's low two bits.
- R4: In both windows, the window-relative byte offset decides which sizes are legal. Offset 0 accepts sizes 1, 2 and 4. Offset 2 accepts sizes 1 and 2. Offsets 1 and 3 accept only size 1. Any size other than 1, 2 or 4 is illegal everywhere.
- R5: The I/O window is big-endian. dn_be bit k and dn_wdata bits [8k+7:8k] belong to bus byte lane k. The byte at dn_addr maps to lane dn_addr[1:0] and holds the most significant byte of the right-justified CPU value. Read data is reassembled in the same order.
- R6: The configuration window is little-endian. The least significant byte of the CPU value goes to lane dn_addr[1:0], and read data is reassembled in the same order.
- R7: A write to offset 0x05C keeps only data bits [1:0]. Reads return them with the upper bits zero.
- R8: A write to offset 0x020 stores 0xFFFA0030 ORed with (data & 0x0001E000). The reset value of this register is 0xFFFA0030.
- R9: An access to an unmapped offset, or with an illegal size, completes with cpu_done and cpu_err both high. It issues no downstream request and changes no register. The side registers and the address register accept only 4-byte accesses at their exact offset.
- R10: A downstream request keeps dn_addr, dn_be, dn_wdata, dn_io, dn_wr and dn_size stable until dn_ack is sampled high, and cpu_ready stays low during that time. cpu_done is raised in the cycle after the acknowledge, with the reassembled read data on cpu_rdata.
- R11: A legal access to the address register or to a side register raises cpu_done in the cycle after acceptance and issues no downstream request.
- R12: After reset, the address register reads 0, the fast back-to-back register reads 0, cpu_ready is high and dn_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_addr | input | 12 | Byte offset in the register page |
| cpu_size | input | 3 | Access size in bytes (1, 2 or 4) |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_wdata | input | 32 | Write data, right-justified |
| cpu_ready | output | 1 | Block can take a new access |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Error response, valid with cpu_done |
| cpu_rdata | output | 32 | Read data, right-justified, valid with cpu_done |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_io | output | 1 | 1 for I/O space, 0 for configuration space |
| dn_wr | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream byte address |
| dn_size | output | 3 | Downstream size in bytes |
| dn_be | output | 4 | Byte-lane enables |
| dn_wdata | output | 32 | Lane-positioned write data |
| dn_ack | input | 1 | Transaction engine acknowledge |
| dn_rdata | input | 32 | Lane-positioned read data, valid with dn_ack |

## Verification
The bench loads an address with bits [1:0] set. It then confirms that readback keeps those bits while downstream addresses drop them, and that configuration addresses OR the offset in while I/O addresses add it. A design that forwarded the raw value would show the wrong dn_addr. Every size and offset pair in both windows that should be refused is tried, and after each one the bench checks that no request appeared and that the side registers still read back unchanged. A lenient decoder would let a stray request or register write through. Matching write and read patterns through both windows expose a byte order swapped in either window. Delayed acknowledges expose a request that drops or changes before the engine has taken it.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_TOC,
      TGT_FBB,
      TGT_CADDR,
      TGT_CDATA,
      TGT_IODATA
   } tgt_e;

   // R4: lane legality inside a data window
   function automatic logic size_fits(input logic [1:0] off, input logic [2:0] size);
      case (off)
         2'd0:    return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
         2'd2:    return (size == 3'd1) || (size == 3'd2);
         default: return (size == 3'd1);
      endcase
   endfunction

   function automatic logic is_window(input tgt_e t);
      return (t == TGT_CDATA) || (t == TGT_IODATA);
   endfunction

endpackage

// File: rtl/pcicfg_decode.sv
module pcicfg_decode
   import pcicfg_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] TOC_OFS    = 'h020,
   parameter logic [ADDR_W-1:0] FBB_OFS    = 'h05C,
   parameter logic [ADDR_W-1:0] CADDR_OFS  = 'h064,
   parameter logic [ADDR_W-1:0] CDATA_OFS  = 'h068,
   parameter logic [ADDR_W-1:0] IODATA_OFS = 'h06C
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output tgt_e              tgt,
   output logic              legal
);

   if (ADDR_W < 8) begin : g_chk_w
      $error("pcicfg_decode: ADDR_W too small");
   end
   if ((TOC_OFS[1:0] | FBB_OFS[1:0] | CADDR_OFS[1:0] | CDATA_OFS[1:0] | IODATA_OFS[1:0]) != 2'b00) begin : g_chk_align
      $error("pcicfg_decode: register offsets must be word aligned");
   end

   always_comb begin
      tgt   = TGT_NONE;
      legal = 1'b0;
      if (addr == TOC_OFS) begin
         tgt   = TGT_TOC;
         legal = (size == 3'd4);
      end else if (addr == FBB_OFS) begin
         tgt   = TGT_FBB;
         legal = (size == 3'd4);
      end else if (addr == CADDR_OFS) begin
         tgt   = TGT_CADDR;
         legal = (size == 3'd4);
      end else if (addr[ADDR_W-1:2] == CDATA_OFS[ADDR_W-1:2]) begin
         tgt   = TGT_CDATA;
         legal = size_fits(addr[1:0], size);
      end else if (addr[ADDR_W-1:2] == IODATA_OFS[ADDR_W-1:2]) begin
         tgt   = TGT_IODATA;
         legal = size_fits(addr[1:0], size);
      end
   end

endmodule

// File: rtl/pcicfg_lanes.sv
module pcicfg_lanes #(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [1:0]  off,
   input  logic [2:0]  size,
   input  logic [31:0] cpu_val,
   input  logic [31:0] bus_val,
   output logic [3:0]  be,
   output logic [31:0] bus_out,
   output logic [31:0] cpu_out
);

   logic [2:0] nsz;
   assign nsz = (size > 3'd4) ? 3'd4 : size;

   if (BIG_ENDIAN) begin : g_big
      always_comb begin
         int lane;
         int src;
         be      = '0;
         bus_out = '0;
         cpu_out = '0;
         for (int i = 0; i < 4; i++) begin
            lane = (int'(off) + i) % 4;
            src  = int'(nsz) - 1 - i;
            if (i < int'(nsz)) begin
               be[lane]              = 1'b1;
               bus_out[8*lane +: 8]  = cpu_val[8*src +: 8];
               cpu_out[8*src +: 8]   = bus_val[8*lane +: 8];
            end
         end
      end
   end else begin : g_little
      always_comb begin
         int lane;
         be      = '0;
         bus_out = '0;
         cpu_out = '0;
         for (int i = 0; i < 4; i++) begin
            lane = (int'(off) + i) % 4;
            if (i < int'(nsz)) begin
               be[lane]             = 1'b1;
               bus_out[8*lane +: 8] = cpu_val[8*i +: 8];
               cpu_out[8*i +: 8]    = bus_val[8*lane +: 8];
            end
         end
      end
   end

endmodule

// File: rtl/pcicfg_regs.sv
module pcicfg_regs #(
   parameter int          FBB_W    = 2,
   parameter logic [31:0] TOC_BASE = 32'hFFFA_0030,
   parameter logic [31:0] TOC_MASK = 32'h0001_E000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_caddr,
   input  logic             wr_fbb,
   input  logic             wr_toc,
   input  logic [31:0]      wdata,
   output logic [31:0]      caddr_raw,
   output logic [FBB_W-1:0] fbb,
   output logic [31:0]      toc
);

   if (FBB_W < 1 || FBB_W > 32) begin : g_chk_fbb
      $error("pcicfg_regs: FBB_W out of range");
   end
   if ((TOC_BASE & TOC_MASK) != 32'h0) begin : g_chk_toc
      $error("pcicfg_regs: TOC_BASE and TOC_MASK overlap");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         caddr_raw <= '0;
         fbb       <= '0;
         toc       <= TOC_BASE;
      end else begin
         if (wr_caddr) caddr_raw <= wdata;
         if (wr_fbb)   fbb       <= wdata[FBB_W-1:0];
         if (wr_toc)   toc       <= TOC_BASE | (wdata & TOC_MASK);
      end
   end

endmodule

// File: rtl/pcicfg_io_port.sv
module pcicfg_io_port
   import pcicfg_pkg::*;
#(
   parameter int                ADDR_W         = 12,
   parameter logic [ADDR_W-1:0] TOC_OFS        = 'h020,
   parameter logic [ADDR_W-1:0] FBB_OFS        = 'h05C,
   parameter logic [ADDR_W-1:0] CADDR_OFS      = 'h064,
   parameter logic [ADDR_W-1:0] CDATA_OFS      = 'h068,
   parameter logic [ADDR_W-1:0] IODATA_OFS     = 'h06C,
   parameter int                FBB_W          = 2,
   parameter logic [31:0]       TOC_BASE       = 32'hFFFA_0030,
   parameter logic [31:0]       TOC_MASK       = 32'h0001_E000,
   parameter bit                IO_BIG_ENDIAN  = 1'b1,
   parameter bit                CFG_BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [2:0]        cpu_size,
   input  logic              cpu_wr,
   input  logic [31:0]       cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic              cpu_err,
   output logic [31:0]       cpu_rdata,
   output logic              dn_req,
   output logic              dn_io,
   output logic              dn_wr,
   output logic [31:0]       dn_addr,
   output logic [2:0]        dn_size,
   output logic [3:0]        dn_be,
   output logic [31:0]       dn_wdata,
   input  logic              dn_ack,
   input  logic [31:0]       dn_rdata
);

   localparam int FBB_PAD = 32 - FBB_W;

   tgt_e              dec_tgt;
   logic              dec_legal;
   logic              pend;
   logic [1:0]        p_off;
   logic [31:0]       caddr_raw;
   logic [FBB_W-1:0]  fbb_q;
   logic [31:0]       toc_q;
   logic [31:0]       eff_addr;
   logic              accept;
   logic              acc_io;
   logic [1:0]        ln_off;
   logic [2:0]        ln_size;
   logic [3:0]        io_be,   cfg_be;
   logic [31:0]       io_bus,  cfg_bus;
   logic [31:0]       io_cpu,  cfg_cpu;
   logic [31:0]       local_rd;

   pcicfg_decode #(
      .ADDR_W(ADDR_W), .TOC_OFS(TOC_OFS), .FBB_OFS(FBB_OFS),
      .CADDR_OFS(CADDR_OFS), .CDATA_OFS(CDATA_OFS), .IODATA_OFS(IODATA_OFS)
   ) u_dec (
      .addr(cpu_addr), .size(cpu_size), .tgt(dec_tgt), .legal(dec_legal)
   );

   assign cpu_ready = !pend;
   assign accept    = cpu_req && !pend;
   assign acc_io    = (dec_tgt == TGT_IODATA);
   assign eff_addr  = {caddr_raw[31:2], 2'b00};

   pcicfg_regs #(
      .FBB_W(FBB_W), .TOC_BASE(TOC_BASE), .TOC_MASK(TOC_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_caddr(accept && dec_legal && cpu_wr && dec_tgt == TGT_CADDR),
      .wr_fbb  (accept && dec_legal && cpu_wr && dec_tgt == TGT_FBB),
      .wr_toc  (accept && dec_legal && cpu_wr && dec_tgt == TGT_TOC),
      .wdata(cpu_wdata), .caddr_raw(caddr_raw), .fbb(fbb_q), .toc(toc_q)
   );

   // lane steering uses the live access when idle, the held one when pending
   assign ln_off  = pend ? p_off   : cpu_addr[1:0];
   assign ln_size = pend ? dn_size : cpu_size;

   pcicfg_lanes #(.BIG_ENDIAN(IO_BIG_ENDIAN)) u_io_lanes (
      .off(ln_off), .size(ln_size), .cpu_val(cpu_wdata), .bus_val(dn_rdata),
      .be(io_be), .bus_out(io_bus), .cpu_out(io_cpu)
   );

   pcicfg_lanes #(.BIG_ENDIAN(CFG_BIG_ENDIAN)) u_cfg_lanes (
      .off(ln_off), .size(ln_size), .cpu_val(cpu_wdata), .bus_val(dn_rdata),
      .be(cfg_be), .bus_out(cfg_bus), .cpu_out(cfg_cpu)
   );

   always_comb begin
      case (dec_tgt)
         TGT_TOC:   local_rd = toc_q;
         TGT_FBB:   local_rd = {{FBB_PAD{1'b0}}, fbb_q};
         TGT_CADDR: local_rd = caddr_raw;
         default:   local_rd = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         p_off     <= '0;
         cpu_done  <= 1'b0;
         cpu_err   <= 1'b0;
         cpu_rdata <= '0;
         dn_req    <= 1'b0;
         dn_io     <= 1'b0;
         dn_wr     <= 1'b0;
         dn_addr   <= '0;
         dn_size   <= '0;
         dn_be     <= '0;
         dn_wdata  <= '0;
      end else begin
         cpu_done <= 1'b0;
         cpu_err  <= 1'b0;
         if (!pend) begin
            if (cpu_req) begin
               if (!dec_legal) begin
                  cpu_done  <= 1'b1;
                  cpu_err   <= 1'b1;
                  cpu_rdata <= '0;
               end else if (is_window(dec_tgt)) begin
                  pend     <= 1'b1;
                  p_off    <= cpu_addr[1:0];
                  dn_req   <= 1'b1;
                  dn_io    <= acc_io;
                  dn_wr    <= cpu_wr;
                  dn_size  <= cpu_size;
                  dn_addr  <= acc_io ? (eff_addr + {30'd0, cpu_addr[1:0]})
                                     : (eff_addr | {30'd0, cpu_addr[1:0]});
                  dn_be    <= acc_io ? io_be : cfg_be;
                  dn_wdata <= !cpu_wr ? 32'd0 : (acc_io ? io_bus : cfg_bus);
               end else begin
                  cpu_done  <= 1'b1;
                  cpu_rdata <= cpu_wr ? 32'd0 : local_rd;
               end
            end
         end else if (dn_ack) begin
            pend      <= 1'b0;
            dn_req    <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_rdata <= dn_wr ? 32'd0 : (dn_io ? io_cpu : cfg_cpu);
         end
      end
   end

endmodule

// File: rtl/pcicfg_io_port_chk.sv
module pcicfg_io_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_ready,
   input logic        cpu_done,
   input logic        cpu_err,
   input logic        dn_req,
   input logic        dn_ack,
   input logic [31:0] dn_addr,
   input logic [2:0]  dn_size,
   input logic [3:0]  dn_be,
   input logic [31:0] dn_wdata,
   input logic [31:0] caddr_raw
);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_be) && $stable(dn_wdata));

   p_ack_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req && dn_ack |=> cpu_done && !dn_req);

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> !cpu_ready);

   p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> cpu_done && !dn_req);

   p_addr_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> dn_addr[31:2] == caddr_raw[31:2]);

   p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req |-> $countones(dn_be) == int'(dn_size));

endmodule

bind pcicfg_io_port pcicfg_io_port_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
   .cpu_err(cpu_err), .dn_req(dn_req), .dn_ack(dn_ack), .dn_addr(dn_addr),
   .dn_size(dn_size), .dn_be(dn_be), .dn_wdata(dn_wdata), .caddr_raw(caddr_raw)
);

// File: tb/pcicfg_io_port_tb.sv
`timescale 1ns/1ps
module pcicfg_io_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [11:0] cpu_addr = '0;
   logic [2:0]  cpu_size = '0;
   logic        cpu_wr = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_done, cpu_err;
   logic [31:0] cpu_rdata;
   logic        dn_req, dn_io, dn_wr;
   logic [31:0] dn_addr, dn_wdata;
   logic [2:0]  dn_size;
   logic [3:0]  dn_be;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // captured results of the last access
   logic        r_err, r_seen, r_fast, r_io;
   logic [31:0] r_rdata, r_addr, r_wdata;
   logic [3:0]  r_be;

   always #2.5 clk = ~clk;

   pcicfg_io_port dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
      .cpu_size(cpu_size), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_err(cpu_err),
      .cpu_rdata(cpu_rdata), .dn_req(dn_req), .dn_io(dn_io), .dn_wr(dn_wr),
      .dn_addr(dn_addr), .dn_size(dn_size), .dn_be(dn_be), .dn_wdata(dn_wdata),
      .dn_ack(dn_ack), .dn_rdata(dn_rdata)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected<=20000 cycles", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [11:0] a, input logic [2:0] sz, input logic wr,
                      input logic [31:0] wd, input logic [31:0] rsp, input int delay);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = a; cpu_size = sz; cpu_wr = wr; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      r_seen = 1'b0; r_fast = 1'b0; r_err = 1'b0; r_rdata = 'x;
      if (cpu_done) begin
         r_fast = 1'b1; r_err = cpu_err; r_rdata = cpu_rdata;
      end else if (dn_req) begin
         r_seen = 1'b1; r_addr = dn_addr; r_be = dn_be; r_wdata = dn_wdata; r_io = dn_io;
         for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk("R10 request held", {29'd0, dn_req, cpu_ready, cpu_done}, 32'h4);
            chk("R10 address stable", dn_addr, r_addr);
         end
         dn_ack = 1'b1; dn_rdata = rsp;
         @(negedge clk);
         dn_ack = 1'b0; dn_rdata = '0;
         chk("R10 done after ack", {30'd0, cpu_done, dn_req}, 32'h2);
         r_err = cpu_err; r_rdata = cpu_rdata;
      end else begin
         chk("R10 no completion", 32'd0, 32'd1);
      end
   endtask

   task automatic t_reset();
      chk("R12 ready/req", {30'd0, cpu_ready, dn_req}, 32'h2);
      acc(12'h064, 3'd4, 1'b0, 0, 0, 0);
      chk("R12 addr reg reset", r_rdata, 32'h0);
      chk("R11 local done next cycle", {30'd0, r_fast, r_seen}, 32'h2);
      acc(12'h05C, 3'd4, 1'b0, 0, 0, 0);
      chk("R12 fbb reset", r_rdata, 32'h0);
      acc(12'h020, 3'd4, 1'b0, 0, 0, 0);
      chk("R8 toc reset", r_rdata, 32'hFFFA_0030);
   endtask

   task automatic t_addr_reg();
      acc(12'h064, 3'd4, 1'b1, 32'h0000_1237, 0, 0);
      chk("R11 addr write local", {30'd0, r_fast, r_err}, 32'h2);
      acc(12'h064, 3'd4, 1'b0, 0, 0, 0);
      chk("R1 raw readback", r_rdata, 32'h0000_1237);
      acc(12'h064, 3'd2, 1'b1, 32'hFFFF_FFFF, 0, 0);
      chk("R1 short write refused", {30'd0, r_err, r_seen}, 32'h2);
      acc(12'h064, 3'd4, 1'b0, 0, 0, 0);
      chk("R1 unchanged after refused", r_rdata, 32'h0000_1237);
   endtask

   task automatic t_cfg();
      acc(12'h06B, 3'd1, 1'b1, 32'h0000_005A, 0, 0);
      chk("R2 cfg addr or", r_addr, 32'h0000_1237);
      chk("R2 cfg space", {31'd0, r_io}, 32'h0);
      chk("R6 cfg be", {28'd0, r_be}, 32'h8);
      chk("R6 cfg wdata", r_wdata, 32'h5A00_0000);
      acc(12'h068, 3'd2, 1'b0, 0, 32'h1122_3344, 3);
      chk("R2 cfg read addr", r_addr, 32'h0000_1234);
      chk("R6 cfg read data", r_rdata, 32'h0000_3344);
      acc(12'h068, 3'd4, 1'b1, 32'hA1B2_C3D4, 0, 2);
      chk("R6 cfg word lanes", r_wdata, 32'hA1B2_C3D4);
      chk("R6 cfg word be", {28'd0, r_be}, 32'hF);
   endtask

   task automatic t_io();
      acc(12'h064, 3'd4, 1'b1, 32'h0000_0303, 0, 0);
      acc(12'h06C, 3'd4, 1'b1, 32'hA1B2_C3D4, 0, 1);
      chk("R3 io addr", r_addr, 32'h0000_0300);
      chk("R3 io space", {31'd0, r_io}, 32'h1);
      chk("R5 io word swap", r_wdata, 32'hD4C3_B2A1);
      acc(12'h06E, 3'd2, 1'b1, 32'h0000_BEEF, 0, 0);
      chk("R3 io addr +2", r_addr, 32'h0000_0302);
      chk("R5 io half be", {28'd0, r_be}, 32'hC);
      chk("R5 io half lanes", r_wdata, 32'hEFBE_0000);
      acc(12'h06D, 3'd1, 1'b0, 0, 32'h0000_7700, 0);
      chk("R3 io addr +1", r_addr, 32'h0000_0301);
      chk("R5 io byte read", r_rdata, 32'h0000_0077);
      acc(12'h06C, 3'd2, 1'b0, 0, 32'hFFFF_2211, 4);
      chk("R5 io half read", r_rdata, 32'h0000_1122);
      acc(12'h06F, 3'd1, 1'b0, 0, 32'h9900_0000, 0);
      chk("R4 io byte at 3 legal", {30'd0, r_err, r_seen}, 32'h1);
      chk("R5 io byte 3 read", r_rdata, 32'h0000_0099);
   endtask

   task automatic t_illegal();
      logic [11:0] a [7] = '{12'h06E, 12'h06D, 12'h06F, 12'h06A, 12'h06C, 12'h100, 12'h020};
      logic [2:0]  s [7] = '{3'd4,    3'd2,    3'd2,    3'd4,    3'd3,    3'd4,    3'd1};
      for (int i = 0; i < 7; i++) begin
         acc(a[i], s[i], 1'b1, 32'hFFFF_FFFF, 0, 0);
         chk("R4 R9 illegal err no req", {30'd0, r_err, r_seen}, 32'h2);
      end
      acc(12'h020, 3'd4, 1'b0, 0, 0, 0);
      chk("R9 toc untouched", r_rdata, 32'hFFFA_0030);
      acc(12'h064, 3'd4, 1'b0, 0, 0, 0);
      chk("R9 addr untouched", r_rdata, 32'h0000_0303);
   endtask

   task automatic t_side();
      acc(12'h05C, 3'd4, 1'b1, 32'hFFFF_FFFF, 0, 0);
      acc(12'h05C, 3'd4, 1'b0, 0, 0, 0);
      chk("R7 fbb keeps two bits", r_rdata, 32'h0000_0003);
      acc(12'h020, 3'd4, 1'b1, 32'hFFFF_FFFF, 0, 0);
      acc(12'h020, 3'd4, 1'b0, 0, 0, 0);
      chk("R8 toc masked", r_rdata, 32'hFFFB_E030);
      acc(12'h020, 3'd4, 1'b1, 32'h0000_0000, 0, 0);
      acc(12'h020, 3'd4, 1'b0, 0, 0, 0);
      chk("R8 toc base", r_rdata, 32'hFFFA_0030);
      acc(12'h05C, 3'd2, 1'b1, 32'h0, 0, 0);
      chk("R9 fbb short refused", {31'd0, r_err}, 32'h1);
      acc(12'h05C, 3'd4, 1'b0, 0, 0, 0);
      chk("R9 fbb unchanged", r_rdata, 32'h0000_0003);
   endtask

   task automatic t_no_enable();
      acc(12'h064, 3'd4, 1'b1, 32'h0000_0040, 0, 0);
      acc(12'h069, 3'd1, 1'b0, 0, 32'h0000_AB00, 0);
      chk("R2 no enable check", {31'd0, r_seen}, 32'h1);
      chk("R2 addr bit31 clear", r_addr, 32'h0000_0041);
      chk("R6 cfg byte read", r_rdata, 32'h0000_00AB);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_reg();
      t_cfg();
      t_io();
      t_illegal();
      t_side();
      t_no_enable();
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule